// File: doc/BRIEF.md
# AES3 Biphase-Mark Frame Transmitter

This block produces a single stereo AES3 / S/PDIF line stream. Each clock cycle is one half-cell of the line code, so the output runs at twice the bit rate. The block counts half-cells, subframes and frames over a 192-frame block. For every subframe it assembles a preamble, a 24-bit audio slot, the validity, user, channel-status and parity bits. It then biphase-mark encodes that word onto a registered line output.

Stereo samples arrive as parallel words, right-justified within a configurable length of 16 to 24 bits. They are captured once per frame. A small status/user buffer holds four bytes per channel for each of the two kinds of bit, and it is written through a simple byte port. Channel-status byte 23 of every block is replaced by a CRC-8 that the block computes over the status bits it has just sent. A mute input zeroes the audio slot and leaves framing untouched.

Top module: `aes3_frame_tx`

## Requirements
- R1: While `rst` is high, `line_out` is 0. After `rst` falls, the first subframe begins with a frame-0 preamble, and the encoder's previous line level is taken as 0.
- R2: Preamble half-cells, first to last, are Z=11101000 for the left subframe of block frame 0, X=11100010 for every other left subframe and Y=11100100 for every right subframe. Each half-cell is XORed with the line level just before the preamble.
- R3: In slots 4 to 31 the line toggles at the start of every bit cell and toggles again mid-cell exactly when the bit is 1.
- R4: Slot 4 carries the LSB of the 24-bit audio slot and slot 27 its MSB. The slot holds the sample shifted left by 24 minus the effective word length. The effective length is `word_len` clamped to the range 16 to 24, and sample bits above it are dropped.
- R5: With `mute` set for a frame, both audio slots of that frame are zero, while preamble, V, U and C stay as without mute.
- R6: Slot 28 (V) equals the `invalid` input captured for the frame.
- R7: Slot 31 makes the count of ones in slots 4 to 31 even.
- R8: Slot 30 (C) of block frame f<32 is bit f%8 of status byte f/8 of that channel. For 32<=f<184 it is 0.
- R9: Slot 29 (U) of block frame f<32 is bit f%8 of user byte f/8 of that channel. For f>=32 it is 0.
- R10: For block frames 184 to 191, C carries bits 0 to 7 of a CRC of that channel. The CRC starts at 0xFF at frame 0 and steps once per C bit sent in frames 0 to 183 as c = {c[6:0],0} ^ (c[7]^d ? 0x1D : 0).
- R11: After reset, every buffer byte reads as 0 until it is written again.
- R12: `left_pcm`, `right_pcm`, `word_len`, `mute` and `invalid` are captured on the clock edge that emits a frame's first half-cell, and they serve both subframes of that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-cell clock |
| rst | input | 1 | Synchronous active-high reset |
| left_pcm | input | 24 | Left sample, right-justified |
| right_pcm | input | 24 | Right sample, right-justified |
| word_len | input | 5 | Sample word length in bits |
| mute | input | 1 | Zero the audio slots |
| invalid | input | 1 | Validity flag value for the frame |
| buf_we | input | 1 | Buffer byte write strobe |
| buf_user | input | 1 | 0 = status buffer, 1 = user buffer |
| buf_chan | input | 1 | 0 = left, 1 = right |
| buf_idx | input | 2 | Byte index in the buffer |
| buf_wdata | input | 8 | Byte to write |
| line_out | output | 1 | Biphase-mark line level |

## Verification
Frame inputs are latched on the edge that emits the frame's first half-cell, and that half-cell appears at `line_out` right after that edge. Half-cell n after reset release is therefore read on the falling edge that follows rising edge n+1. The bench counts falling edges from release, decodes each 64-half-cell subframe only once all of its cells are in, and changes frame inputs just after the latching edge so that each value lands in the following frame. Buffer writes go in 40 frames into a block, so they first show up in the status bits of the next block.

// File: rtl/aes_tx_pkg.sv
package aes_tx_pkg;
  localparam int AUD_SLOT = 24;
  localparam int SUB_HALF = 64;
  localparam int LOAD_HC  = 7;
  localparam logic [7:0] PRE_Z = 8'b11101000;
  localparam logic [7:0] PRE_X = 8'b11100010;
  localparam logic [7:0] PRE_Y = 8'b11100100;
  localparam logic [7:0] CRC_POLY = 8'h1D;
  localparam logic [7:0] CRC_INIT = 8'hFF;

  typedef struct packed {
    logic                par;
    logic                cs;
    logic                ud;
    logic                vf;
    logic [AUD_SLOT-1:0] aud;
  } subword_t;

  function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic d);
    logic fb;
    fb = c[7] ^ d;
    return {c[6:0], 1'b0} ^ (fb ? CRC_POLY : 8'h00);
  endfunction
endpackage

// File: rtl/aes_tx_timing.sv
module aes_tx_timing #(
  parameter int BLOCK_FRAMES = 192,
  parameter int FRAME_W = $clog2(BLOCK_FRAMES)
) (
  input  logic               clk,
  input  logic               rst,
  output logic [5:0]         hc,
  output logic               chan,
  output logic [FRAME_W-1:0] frame
);
  localparam logic [FRAME_W-1:0] LAST_FRAME = FRAME_W'(BLOCK_FRAMES - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      hc    <= '0;
      chan  <= 1'b0;
      frame <= '0;
    end else begin
      hc <= hc + 6'd1;
      if (hc == 6'd63) begin
        chan <= ~chan;
        if (chan) frame <= (frame == LAST_FRAME) ? '0 : frame + 1'b1;
      end
    end
  end

  a_r2_block_wrap: assert property (@(posedge clk) disable iff (rst)
    (hc == 6'd63 && chan && frame == LAST_FRAME) |=> (frame == '0 && !chan && hc == 6'd0));
endmodule

// File: rtl/aes_tx_chanbuf.sv
module aes_tx_chanbuf #(
  parameter int BUF_BYTES = 4,
  parameter int IDX_W = $clog2(BUF_BYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic             wuser,
  input  logic             wchan,
  input  logic [IDX_W-1:0] widx,
  input  logic [7:0]       wdata,
  input  logic             rchan,
  input  logic [IDX_W-1:0] ridx,
  output logic [7:0]       cs_byte,
  output logic [7:0]       ud_byte
);
  localparam int DEPTH  = 2 * BUF_BYTES;
  localparam int ADDR_W = IDX_W + 1;

  logic [7:0] cs_mem [DEPTH];
  logic [7:0] ud_mem [DEPTH];
  logic [DEPTH-1:0] cs_ok, ud_ok;
  logic [7:0] cs_rd, ud_rd;
  logic       cs_okq, ud_okq;
  logic [ADDR_W-1:0] waddr, raddr;

  assign waddr = {wchan, widx};
  assign raddr = {rchan, ridx};

  always_ff @(posedge clk) begin
    if (we && !wuser) cs_mem[waddr] <= wdata;
    cs_rd <= cs_mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (we && wuser) ud_mem[waddr] <= wdata;
    ud_rd <= ud_mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_ok  <= '0;
      ud_ok  <= '0;
      cs_okq <= 1'b0;
      ud_okq <= 1'b0;
    end else begin
      if (we && !wuser) cs_ok[waddr] <= 1'b1;
      if (we && wuser)  ud_ok[waddr] <= 1'b1;
      cs_okq <= cs_ok[raddr];
      ud_okq <= ud_ok[raddr];
    end
  end

  assign cs_byte = cs_okq ? cs_rd : 8'h00;
  assign ud_byte = ud_okq ? ud_rd : 8'h00;

  a_r11_clear_after_reset: assert property (@(posedge clk) rst |=> (cs_byte == 8'h00 && ud_byte == 8'h00));
endmodule

// File: rtl/aes_tx_subframe.sv
module aes_tx_subframe
  import aes_tx_pkg::*;
#(
  parameter int FRAME_W = 8,
  parameter int BUF_BYTES = 4,
  parameter int CRC_BYTE = 23
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [5:0]          hc,
  input  logic                chan,
  input  logic [FRAME_W-1:0]  frame,
  input  logic [AUD_SLOT-1:0] left_pcm,
  input  logic [AUD_SLOT-1:0] right_pcm,
  input  logic [4:0]          word_len,
  input  logic                mute,
  input  logic                invalid,
  input  logic [7:0]          cs_byte,
  input  logic [7:0]          ud_byte,
  output subword_t            word_q
);
  localparam logic [FRAME_W-1:0] BUF_BITS  = FRAME_W'(BUF_BYTES * 8);
  localparam logic [FRAME_W-1:0] CRC_START = FRAME_W'(CRC_BYTE * 8);

  logic [AUD_SLOT-1:0] lat_l, lat_r;
  logic [4:0]          lat_wl;
  logic                lat_mute, lat_inv;
  logic [1:0][7:0]     crc_q;
  logic [4:0]          eff_wl, shamt;
  logic [AUD_SLOT-1:0] aligned;
  logic                c_bit, u_bit;
  subword_t            word_d;
  logic                load;

  assign load = (hc == 6'(LOAD_HC));

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_l <= '0; lat_r <= '0; lat_wl <= 5'd24; lat_mute <= 1'b0; lat_inv <= 1'b0;
    end else if (hc == 6'd0 && !chan) begin
      lat_l <= left_pcm; lat_r <= right_pcm; lat_wl <= word_len;
      lat_mute <= mute; lat_inv <= invalid;
    end
  end

  always_comb begin
    eff_wl = (lat_wl < 5'd16) ? 5'd16 : ((lat_wl > 5'd24) ? 5'd24 : lat_wl);
    shamt  = 5'd24 - eff_wl;
    aligned = (chan ? lat_r : lat_l) << shamt;
    if (frame < BUF_BITS) c_bit = cs_byte[frame[2:0]];
    else if (frame >= CRC_START) c_bit = crc_q[chan][frame[2:0]];
    else c_bit = 1'b0;
    u_bit = (frame < BUF_BITS) ? ud_byte[frame[2:0]] : 1'b0;
    word_d.aud = lat_mute ? '0 : aligned;
    word_d.vf  = lat_inv;
    word_d.ud  = u_bit;
    word_d.cs  = c_bit;
    word_d.par = ^{c_bit, u_bit, lat_inv, word_d.aud};
  end

  always_ff @(posedge clk) begin
    if (rst) word_q <= '0;
    else if (load) word_q <= word_d;
  end

  always_ff @(posedge clk) begin
    if (rst) crc_q <= {CRC_INIT, CRC_INIT};
    else if (load && frame < CRC_START)
      crc_q[chan] <= crc8_step((frame == '0) ? CRC_INIT : crc_q[chan], c_bit);
  end

  a_r8_cs_quiet: assert property (@(posedge clk) disable iff (rst)
    (load && frame >= BUF_BITS && frame < CRC_START) |=> !word_q.cs);
  a_r9_ud_quiet: assert property (@(posedge clk) disable iff (rst)
    (load && frame >= BUF_BITS) |=> !word_q.ud);
  a_r5_mute_zero: assert property (@(posedge clk) disable iff (rst)
    (load && lat_mute) |=> (word_q.aud == '0));
endmodule

// File: rtl/aes_tx_bmc.sv
module aes_tx_bmc
  import aes_tx_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic [5:0] hc,
  input  logic     chan,
  input  logic     first_frame,
  input  subword_t word_q,
  output logic     line_out
);
  logic [7:0]  pat;
  logic        base;
  logic [4:0]  bidx;
  logic [31:0] bits;

  assign pat  = chan ? PRE_Y : (first_frame ? PRE_Z : PRE_X);
  assign bidx = hc[5:1] - 5'd4;
  assign bits = {4'b0000, word_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      line_out <= 1'b0;
      base     <= 1'b0;
    end else if (hc < 6'd8) begin
      if (hc == 6'd0) begin
        base     <= line_out;
        line_out <= pat[7] ^ line_out;
      end else begin
        line_out <= pat[3'd7 - hc[2:0]] ^ base;
      end
    end else if (!hc[0]) begin
      line_out <= ~line_out;
    end else if (bits[bidx]) begin
      line_out <= ~line_out;
    end
  end

  a_r1_reset_low: assert property (@(posedge clk) rst |=> !line_out);
  a_r2_preamble_entry: assert property (@(posedge clk) disable iff (rst)
    (hc == 6'd0) |=> (line_out != $past(line_out)));
  a_r3_cell_edge: assert property (@(posedge clk) disable iff (rst)
    (hc >= 6'd8 && !hc[0]) |=> (line_out != $past(line_out)));
  a_r7_even_close: assert property (@(posedge clk) disable iff (rst)
    (hc == 6'd63) |=> (line_out == $past(base)));
endmodule

// File: rtl/aes3_frame_tx.sv
module aes3_frame_tx
  import aes_tx_pkg::*;
#(
  parameter int BLOCK_FRAMES = 192,
  parameter int BUF_BYTES = 4,
  parameter int CRC_BYTE = 23,
  parameter int IDX_W = $clog2(BUF_BYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [23:0]      left_pcm,
  input  logic [23:0]      right_pcm,
  input  logic [4:0]       word_len,
  input  logic             mute,
  input  logic             invalid,
  input  logic             buf_we,
  input  logic             buf_user,
  input  logic             buf_chan,
  input  logic [IDX_W-1:0] buf_idx,
  input  logic [7:0]       buf_wdata,
  output logic             line_out
);
  localparam int FRAME_W = $clog2(BLOCK_FRAMES);

  logic [5:0]         hc;
  logic               chan;
  logic [FRAME_W-1:0] frame;
  logic [7:0]         cs_byte, ud_byte;
  subword_t           word_q;

  aes_tx_timing #(.BLOCK_FRAMES(BLOCK_FRAMES), .FRAME_W(FRAME_W)) u_timing (
    .clk(clk), .rst(rst), .hc(hc), .chan(chan), .frame(frame));

  aes_tx_chanbuf #(.BUF_BYTES(BUF_BYTES), .IDX_W(IDX_W)) u_buf (
    .clk(clk), .rst(rst), .we(buf_we), .wuser(buf_user), .wchan(buf_chan),
    .widx(buf_idx), .wdata(buf_wdata), .rchan(chan), .ridx(frame[3 +: IDX_W]),
    .cs_byte(cs_byte), .ud_byte(ud_byte));

  aes_tx_subframe #(.FRAME_W(FRAME_W), .BUF_BYTES(BUF_BYTES), .CRC_BYTE(CRC_BYTE)) u_sub (
    .clk(clk), .rst(rst), .hc(hc), .chan(chan), .frame(frame),
    .left_pcm(left_pcm), .right_pcm(right_pcm), .word_len(word_len),
    .mute(mute), .invalid(invalid), .cs_byte(cs_byte), .ud_byte(ud_byte),
    .word_q(word_q));

  aes_tx_bmc u_bmc (
    .clk(clk), .rst(rst), .hc(hc), .chan(chan), .first_frame(frame == '0),
    .word_q(word_q), .line_out(line_out));
endmodule

// File: tb/tb_aes3_frame_tx.sv
`timescale 1ns/1ps
module tb_aes3_frame_tx;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [23:0] left_pcm, right_pcm;
  logic [4:0] word_len;
  logic mute, invalid;
  logic buf_we = 1'b0, buf_user = 1'b0, buf_chan = 1'b0;
  logic [1:0] buf_idx = 2'd0;
  logic [7:0] buf_wdata = 8'h00;
  logic line_out;

  always #2.5 clk = ~clk;

  aes3_frame_tx dut (
    .clk(clk), .rst(rst), .left_pcm(left_pcm), .right_pcm(right_pcm),
    .word_len(word_len), .mute(mute), .invalid(invalid), .buf_we(buf_we),
    .buf_user(buf_user), .buf_chan(buf_chan), .buf_idx(buf_idx),
    .buf_wdata(buf_wdata), .line_out(line_out));

  // {left, right, word_len, mute, invalid}
  localparam logic [54:0] VEC [0:7] = '{
    {24'h123456, 24'hABCDEF, 5'd24, 1'b0, 1'b0},
    {24'h00BEEF, 24'h007A5C, 5'd16, 1'b0, 1'b0},
    {24'h0F1234, 24'h054321, 5'd20, 1'b0, 1'b0},
    {24'hFFFFFF, 24'h800001, 5'd24, 1'b1, 1'b0},
    {24'h000001, 24'h7FFFFF, 5'd24, 1'b0, 1'b1},
    {24'h00C3A5, 24'h001234, 5'd12, 1'b0, 1'b0},
    {24'h5A5A5A, 24'hA5A5A5, 5'd30, 1'b0, 1'b1},
    {24'h03FFFF, 24'hFC0001, 5'd18, 1'b0, 1'b0}
  };
  localparam int WSTART = 128 * 40 + 5;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  int k, seg;
  logic h [0:63];
  logic prevl;
  logic [7:0] m_data [0:1][0:1][0:3];
  bit m_ok [0:1][0:1][0:3];
  logic [7:0] ecrc [0:1];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] ebyte(input int user, input int ch, input int idx);
    return (idx < 4 && m_ok[user][ch][idx]) ? m_data[user][ch][idx] : 8'h00;
  endfunction

  task automatic apply_vec(input int g);
    logic [54:0] v;
    v = VEC[g % 8];
    left_pcm = v[54:31]; right_pcm = v[30:7]; word_len = v[6:2];
    mute = v[1]; invalid = v[0];
  endtask

  task automatic decode(input int sf);
    int g, ch, f;
    logic [7:0] actp, expp;
    logic [27:0] bits;
    logic last, bpok, ec, eu;
    logic [54:0] v;
    logic [23:0] smp, ea;
    int wl;
    string ctag, utag;
    g = sf / 2; ch = sf % 2; f = g % 192;
    for (int i = 0; i < 8; i++) actp[7-i] = h[i] ^ prevl;
    expp = ch ? 8'b11100100 : ((f == 0) ? 8'b11101000 : 8'b11100010);
    check(actp == expp, "R2", "preamble", 32'(actp), 32'(expp));
    bpok = 1'b1; last = h[7];
    for (int s = 4; s < 32; s++) begin
      if (h[2*s] == last) bpok = 1'b0;
      bits[s-4] = h[2*s] ^ h[2*s+1];
      last = h[2*s+1];
    end
    check(bpok, "R3", "cell boundary toggle", 32'(bpok), 32'd1);
    prevl = h[63];
    v = VEC[g % 8];
    smp = ch ? v[30:7] : v[54:31];
    wl = int'(v[6:2]);
    if (wl < 16) wl = 16;
    if (wl > 24) wl = 24;
    ea = v[1] ? 24'h0 : 24'(smp << (24 - wl));
    if (v[1]) check(bits[23:0] == ea, "R5", "muted audio", 32'(bits[23:0]), 32'(ea));
    else check(bits[23:0] == ea, "R4 R12", "audio slot", 32'(bits[23:0]), 32'(ea));
    check(bits[24] == v[0], "R6", "validity", 32'(bits[24]), 32'(v[0]));
    eu = (f < 32) ? ebyte(1, ch, f / 8)[f % 8] : 1'b0;
    utag = (seg == 1 && f < 32) ? "R11" : "R9";
    check(bits[25] == eu, utag, "user bit", 32'(bits[25]), 32'(eu));
    if (f < 32) ec = ebyte(0, ch, f / 8)[f % 8];
    else if (f >= 184) ec = ecrc[ch][f-184];
    else ec = 1'b0;
    ctag = (f >= 184) ? "R10" : ((seg == 1 && f < 32) ? "R11" : "R8");
    check(bits[26] == ec, ctag, "status bit", 32'(bits[26]), 32'(ec));
    if (f < 184) begin
      logic [7:0] c;
      logic fb;
      c = (f == 0) ? 8'hFF : ecrc[ch];
      fb = c[7] ^ ec;
      ecrc[ch] = {c[6:0], 1'b0} ^ (fb ? 8'h1D : 8'h00);
    end
    check((^bits) == 1'b0, "R7", "even parity", 32'(^bits), 32'd0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    apply_vec(0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(line_out == 1'b0, "R1", "line low in reset", 32'(line_out), 32'd0);
    end
    for (int u = 0; u < 2; u++)
      for (int c = 0; c < 2; c++)
        for (int i = 0; i < 4; i++) m_ok[u][c][i] = 1'b0;
    k = 0; prevl = 1'b0;
    rst = 1'b0;
  endtask

  task automatic run(input int edges, input bit do_writes);
    for (int n = 0; n < edges; n++) begin
      @(negedge clk);
      k++;
      h[(k-1) % 64] = line_out;
      if (k % 64 == 0) decode(k / 64 - 1);
      if ((k - 1) % 128 == 0) apply_vec((k - 1) / 128 + 1);
      buf_we = 1'b0;
      if (do_writes && k >= WSTART && k < WSTART + 32 && (k - WSTART) % 2 == 0) begin
        int i;
        i = (k - WSTART) / 2;
        if (i != 15) begin
          buf_we = 1'b1; buf_user = i[3]; buf_chan = i[2]; buf_idx = i[1:0];
          buf_wdata = 8'(i * 37 + 11);
          m_data[i/8][(i/4)%2][i%4] = buf_wdata;
          m_ok[i/8][(i/4)%2][i%4] = 1'b1;
        end
      end
    end
  endtask

  initial begin
    seg = 0;
    do_reset();
    // First subframe after release must be a frame-0 preamble (R1).
    run(2 * 192 * 128, 1'b1);
    // Mid-stream reset: output low, buffer defaults return (R1, R11).
    seg = 1;
    do_reset();
    run(40 * 128, 1'b0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule